// File: doc/BRIEF.md
# TDMA Slot Synchronizer

This block keeps the local time-slot counter of a power line modem aligned with the rest of a time-division network. One time slot is exactly one physical frame: a fixed number of bit periods, 360 by default. That is fifteen mains cycles at 24 bits per cycle, or seven and a half at 48 bits per cycle. A bit strobe from the demodulator advances a bit index through the slot. A one-clock slot-start pulse marks each new slot.

In master mode the node sets the timing. Its first slot opens on the first mains zero-crossing strobe. From then on, slots are counted in bit periods only, because at 48 bits per cycle a slot boundary falls in the middle of a mains cycle.

In slave mode the node follows the master. The received bits are shifted, most significant bit first, into a 32-bit window. When the window holds the 16-bit preamble 0xAAAA followed by the 16-bit delimiter 0x54C7, the block reports a frame and forces the bit index to 32, the position just after the delimiter. A lock flag shows whether frames are still arriving.

Top module: `tdma_slot_sync`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `bit_idx` is 0, and `slot_start`, `frame_found` and `locked` are 0.
- R2: In master mode, before the first zero-crossing strobe, bit strobes leave `bit_idx` at 0 and produce no `slot_start`.
- R3: In master mode, the first `zc_stb` produces a one-clock `slot_start`, sets `bit_idx` to 0 and sets `locked`. Later zero-crossing strobes change neither `bit_idx` nor `slot_start`.
- R4: Once counting, each `bit_stb` raises `bit_idx` by one. The strobe that finds `bit_idx` at SLOT_BITS-1 sets it to 0 and gives a `slot_start` pulse exactly one clock wide.
- R5: In slave mode, `rx_bit` is taken on each `bit_stb`. When the last 32 bits received, oldest first, equal 0xAAAA54C7, the same update gives a one-clock `frame_found`, sets `bit_idx` to 32 and sets `locked`.
- R6: A 32-bit sequence that differs from 0xAAAA54C7 in any bit gives no `frame_found`, and `bit_idx` simply advances.
- R7: In slave mode the slot counter runs from reset, with no match needed, and wraps with `slot_start` every SLOT_BITS strobes.
- R8: In slave mode, `locked` is cleared at the MISS_LIMIT-th consecutive slot boundary that closes a slot with no match. A match inside a slot restarts this count.
- R9: A change of `master_mode` returns the block to its reset state within one clock. A new master must then wait for a fresh zero crossing.
- R10: In master mode the received bit stream is not searched: a matching sequence gives no `frame_found` and does not move `bit_idx` from its normal count.
- R11: In slave mode `zc_stb` has no effect on `bit_idx` or `slot_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = master (anchor slots to the mains), 0 = slave (follow received frames) |
| zc_stb | input | 1 | One-clock mains zero-crossing strobe |
| bit_stb | input | 1 | One-clock strobe, one per bit period |
| rx_bit | input | 1 | Demodulated bit, valid with `bit_stb` |
| slot_start | output | 1 | One-clock pulse at the start of each slot |
| bit_idx | output | $clog2(SLOT_BITS) | Bits elapsed in the current slot |
| frame_found | output | 1 | One-clock pulse when the sync sequence completes |
| locked | output | 1 | Slot alignment is held |

## Verification
The bench builds the block with SLOT_BITS = 64 and MISS_LIMIT = 2. The short slot lets a run reach several wraps, and a lock loss, in a few hundred strobes. Its 64 bits still exceed the 32-bit sync window, so the forced index of 32 stays distinct from a wrap. With a miss limit of 2, a run can show both a partial miss count restarted by a fresh match and a complete loss of lock. A table of near-miss sync words, each sent after a five-bit prefix, separates a true match from an ordinary advance by the resulting index (32 against 37).

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int          SYNC_LEN_DEF  = 32;
  localparam logic [31:0] SYNC_WORD_DEF = 32'hAAAA_54C7;
endpackage

// File: rtl/tss_sync_det.sv
module tss_sync_det #(
  parameter int                SYNC_LEN  = tss_pkg::SYNC_LEN_DEF,
  parameter logic [SYNC_LEN-1:0] SYNC_WORD = tss_pkg::SYNC_WORD_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_stb_i,
  input  logic rx_bit_i,
  output logic hit_o
);
  logic [SYNC_LEN-1:0] win_q;
  logic [SYNC_LEN-1:0] win_d;

  assign win_d = {win_q[SYNC_LEN-2:0], rx_bit_i};
  assign hit_o = bit_stb_i && en_i && !clr_i && (win_d == SYNC_WORD);

  always_ff @(posedge clk) begin
    if (rst || clr_i)            win_q <= '0;
    else if (bit_stb_i && en_i)  win_q <= win_d;
  end

  // R10: with the search disabled the window never moves
  p_window_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(win_q));
endmodule

// File: rtl/tss_slot_ctr.sv
module tss_slot_ctr #(
  parameter int SLOT_BITS = 360,
  parameter int SYNC_LEN  = 32,
  localparam int IDX_W    = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             master_i,
  input  logic             zc_i,
  input  logic             bit_stb_i,
  input  logic             force_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             start_o,
  output logic             align_o,
  output logic             wrap_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_BITS - 1);
  localparam logic [IDX_W-1:0] SYNC_IDX = IDX_W'(SYNC_LEN);

  logic anchored_q;
  logic step;

  assign align_o = master_i && !anchored_q && zc_i && !clr_i;
  assign step    = bit_stb_i && (!master_i || anchored_q);
  assign wrap_o  = step && (idx_o == LAST_IDX) && !force_i && !clr_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      idx_o      <= '0;
      start_o    <= 1'b0;
      anchored_q <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (force_i) begin
        idx_o <= SYNC_IDX;
      end else if (align_o) begin
        anchored_q <= 1'b1;
        idx_o      <= '0;
        start_o    <= 1'b1;
      end else if (step) begin
        if (idx_o == LAST_IDX) begin
          idx_o   <= '0;
          start_o <= 1'b1;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end
    end
  end

  // R4: index stays inside the slot
  p_idx_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    idx_o <= LAST_IDX);
  // R4: a slot opens at index zero
  p_start_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (idx_o == '0));
  // R4: the slot-start pulse lasts a single clock
  p_start_one_clk_r4: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  // R2, R3: with no strobe of any kind the index holds
  p_idx_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!bit_stb_i && !zc_i && !force_i && !clr_i) |=> $stable(idx_o));
endmodule

// File: rtl/tss_lock_mon.sv
module tss_lock_mon #(
  parameter int MISS_LIMIT = 4,
  localparam int MISS_W    = $clog2(MISS_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic master_i,
  input  logic hit_i,
  input  logic align_i,
  input  logic wrap_i,
  output logic locked_o,
  output logic found_o
);
  logic              seen_q;
  logic [MISS_W-1:0] miss_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      locked_o <= 1'b0;
      found_o  <= 1'b0;
      seen_q   <= 1'b0;
      miss_q   <= '0;
    end else begin
      found_o <= hit_i;
      if (hit_i) begin
        locked_o <= 1'b1;
        seen_q   <= 1'b1;
        miss_q   <= '0;
      end else if (align_i) begin
        locked_o <= 1'b1;
      end else if (wrap_i && !master_i) begin
        seen_q <= 1'b0;
        if (locked_o) begin
          if (seen_q) begin
            miss_q <= '0;
          end else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
            locked_o <= 1'b0;
            miss_q   <= '0;
          end else begin
            miss_q <= miss_q + 1'b1;
          end
        end
      end
    end
  end

  // R5: a found frame always leaves the block locked
  p_found_sets_lock_r5: assert property (@(posedge clk) disable iff (rst)
    found_o |-> locked_o);
  // R8: lock is lost only at a slot boundary or a mode change
  p_unlock_on_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_o) |-> ($past(wrap_i) || $past(clr_i)));
  // R10: no frame report while staying in master mode
  p_no_found_master_r10: assert property (@(posedge clk) disable iff (rst)
    (master_i && $past(master_i)) |-> !found_o);
endmodule

// File: rtl/tdma_slot_sync.sv
module tdma_slot_sync #(
  parameter int SLOT_BITS  = 360,
  parameter int MISS_LIMIT = 4,
  localparam int SYNC_LEN  = tss_pkg::SYNC_LEN_DEF,
  localparam int IDX_W     = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_mode,
  input  logic             zc_stb,
  input  logic             bit_stb,
  input  logic             rx_bit,
  output logic             slot_start,
  output logic [IDX_W-1:0] bit_idx,
  output logic             frame_found,
  output logic             locked
);
  logic mode_q;
  logic mode_chg;
  logic hit;
  logic align_evt;
  logic wrap;

  always_ff @(posedge clk) begin
    mode_q <= master_mode;
  end

  assign mode_chg = !rst && (master_mode != mode_q);

  tss_sync_det #(
    .SYNC_LEN (SYNC_LEN),
    .SYNC_WORD(tss_pkg::SYNC_WORD_DEF)
  ) u_det (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (mode_chg),
    .en_i     (!master_mode),
    .bit_stb_i(bit_stb),
    .rx_bit_i (rx_bit),
    .hit_o    (hit)
  );

  tss_slot_ctr #(
    .SLOT_BITS(SLOT_BITS),
    .SYNC_LEN (SYNC_LEN)
  ) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (mode_chg),
    .master_i (master_mode),
    .zc_i     (zc_stb),
    .bit_stb_i(bit_stb),
    .force_i  (hit),
    .idx_o    (bit_idx),
    .start_o  (slot_start),
    .align_o  (align_evt),
    .wrap_o   (wrap)
  );

  tss_lock_mon #(
    .MISS_LIMIT(MISS_LIMIT)
  ) u_lock (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (mode_chg),
    .master_i(master_mode),
    .hit_i   (hit),
    .align_i (align_evt),
    .wrap_i  (wrap),
    .locked_o(locked),
    .found_o (frame_found)
  );

  // R5: a reported frame sits just after the delimiter
  p_found_index_r5: assert property (@(posedge clk) disable iff (rst)
    frame_found |-> (bit_idx == IDX_W'(SYNC_LEN)));
  // R9: a mode change leaves the block cleared on the next clock
  p_mode_clear_r9: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (bit_idx == '0 && !locked && !slot_start));
endmodule

// File: tb/test_tdma_slot_sync.sv
module test_tdma_slot_sync;
  localparam int SLOT_BITS  = 64;
  localparam int MISS_LIMIT = 2;
  localparam int IDX_W      = $clog2(SLOT_BITS);
  localparam logic [31:0] SYNC = 32'hAAAA_54C7;
  // {expected match, 32-bit word sent oldest bit first}
  localparam logic [32:0] VEC [5] = '{
    {1'b1, 32'hAAAA_54C7},
    {1'b0, 32'hAAAA_54C6},
    {1'b0, 32'h2AAA_54C7},
    {1'b0, 32'hAAAA_AAAA},
    {1'b0, 32'h54C7_AAAA}
  };

  logic clk = 1'b0;
  logic rst, master_mode, zc_stb, bit_stb, rx_bit;
  logic slot_start, frame_found, locked;
  logic [IDX_W-1:0] bit_idx;
  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tdma_slot_sync #(.SLOT_BITS(SLOT_BITS), .MISS_LIMIT(MISS_LIMIT)) i_tdma_slot_sync (
    .clk(clk), .rst(rst), .master_mode(master_mode), .zc_stb(zc_stb),
    .bit_stb(bit_stb), .rx_bit(rx_bit), .slot_start(slot_start),
    .bit_idx(bit_idx), .frame_found(frame_found), .locked(locked)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; master_mode = m; zc_stb = 1'b0; bit_stb = 1'b0; rx_bit = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    bit_stb = 1'b1; rx_bit = b;
    @(negedge clk);
    bit_stb = 1'b0; rx_bit = 1'b0;
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int b = 31; b >= 0; b--) send_bit(w[b]);
  endtask

  task automatic pulse_zc();
    zc_stb = 1'b1;
    @(negedge clk);
    zc_stb = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1'b1; master_mode = 1'b0; zc_stb = 1'b0; bit_stb = 1'b0; rx_bit = 1'b0;

    // R1 reset state
    do_reset(1'b0);
    check("R1 idx", int'(bit_idx), 0);
    check("R1 slot_start", int'(slot_start), 0);
    check("R1 frame_found", int'(frame_found), 0);
    check("R1 locked", int'(locked), 0);

    // R5 / R6 table of sync words after a five-bit prefix
    for (int v = 0; v < 5; v++) begin
      do_reset(1'b0);
      send_zeros(5);
      send_word(VEC[v][31:0]);
      check(VEC[v][32] ? "R5 found" : "R6 no found", int'(frame_found), int'(VEC[v][32]));
      check(VEC[v][32] ? "R5 idx" : "R6 idx", int'(bit_idx), VEC[v][32] ? 32 : 37);
      check(VEC[v][32] ? "R5 locked" : "R6 locked", int'(locked), int'(VEC[v][32]));
      if (VEC[v][32]) begin
        @(negedge clk);
        check("R5 found one clock", int'(frame_found), 0);
      end
    end

    // R7 slave free-run and R4 wrap
    do_reset(1'b0);
    send_zeros(SLOT_BITS - 1);
    check("R7 idx before wrap", int'(bit_idx), SLOT_BITS - 1);
    check("R7 no early start", int'(slot_start), 0);
    send_bit(1'b0);
    check("R7 wrap start", int'(slot_start), 1);
    check("R7 wrap idx", int'(bit_idx), 0);
    @(negedge clk);
    check("R4 start one clock", int'(slot_start), 0);

    // R11 zero crossing ignored in slave mode
    send_zeros(3);
    pulse_zc();
    check("R11 idx unchanged", int'(bit_idx), 3);
    check("R11 no start", int'(slot_start), 0);

    // R8 lock loss and miss-count restart
    do_reset(1'b0);
    send_word(SYNC);
    check("R8 locked after match", int'(locked), 1);
    send_zeros(32);
    check("R8 wrap after matched slot", int'(slot_start), 1);
    send_zeros(SLOT_BITS);
    check("R8 one miss keeps lock", int'(locked), 1);
    send_word(SYNC);
    check("R8 rematch idx", int'(bit_idx), 32);
    send_zeros(32);
    send_zeros(SLOT_BITS);
    check("R8 count restarted", int'(locked), 1);
    send_zeros(SLOT_BITS - 1);
    check("R8 still locked before boundary", int'(locked), 1);
    send_bit(1'b0);
    check("R8 lock lost", int'(locked), 0);
    check("R8 lost at boundary", int'(slot_start), 1);

    // R2 / R3 / R10 / R4 master mode
    do_reset(1'b1);
    send_zeros(3);
    check("R2 idx waits", int'(bit_idx), 0);
    check("R2 no start", int'(slot_start), 0);
    pulse_zc();
    check("R3 start on zc", int'(slot_start), 1);
    check("R3 idx on zc", int'(bit_idx), 0);
    check("R3 locked on zc", int'(locked), 1);
    @(negedge clk);
    check("R3 start one clock", int'(slot_start), 0);
    send_zeros(10);
    check("R4 counting", int'(bit_idx), 10);
    pulse_zc();
    check("R3 later zc idx", int'(bit_idx), 10);
    check("R3 later zc no start", int'(slot_start), 0);
    send_word(SYNC);
    check("R10 no found", int'(frame_found), 0);
    check("R10 idx normal", int'(bit_idx), 42);
    send_zeros(SLOT_BITS - 43);
    check("R4 last index", int'(bit_idx), SLOT_BITS - 1);
    send_bit(1'b0);
    check("R4 master wrap start", int'(slot_start), 1);
    check("R4 master wrap idx", int'(bit_idx), 0);
    check("R3 master keeps lock", int'(locked), 1);

    // R9 mode changes
    master_mode = 1'b0;
    @(negedge clk);
    check("R9 to slave idx", int'(bit_idx), 0);
    check("R9 to slave locked", int'(locked), 0);
    send_word(SYNC);
    check("R9 slave relock", int'(locked), 1);
    master_mode = 1'b1;
    @(negedge clk);
    check("R9 to master idx", int'(bit_idx), 0);
    check("R9 to master locked", int'(locked), 0);
    send_zeros(2);
    check("R9 master waits zc", int'(bit_idx), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule